// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is one arithmetic slice of a datapath built from repeated multiply-accumulate cells. It sums two operands in a pre-adder and multiplies the sum by a third operand. A post-adder then adds the product to one of three sources: a wide side operand, the slice's own output register (accumulate), or the output of a neighbouring slice shifted down by a fixed amount. The slice's own result is driven out again on a cascade port, so the next slice can pick it up.

Every stage register is optional and chosen by a parameter: the two pre-adder operands, the multiplier operand, the side operand, the pre-adder sum, the product and the result. Each register that is present has its own clock enable. The result register also has a synchronous clear. With every register removed, the slice is a purely combinational path from its inputs to its result. The pre-adder mode code and the post-adder source select are not registered. Each takes effect at the stage that uses it.

Top module: `premac_slice`

## Requirements
- R1: The multiplier's first operand is the signed 25-bit value `a_in[24:0] + d_in`, wrapping modulo 2^25, when `pre_mode` equals 5'b00100. For every other `pre_mode` code it is `a_in[24:0]` alone. `a_in[29:25]` never affects the result.
- R2: The product is a signed 25 x 18 multiply of that operand with `b_in`, sign-extended to 48 bits before the post-adder.
- R3: The result is the product plus a term picked by `z_sel`: 3'b011 adds the side operand `c_in`; 3'b101 adds `casc_in` shifted right arithmetically by 17 bits; 3'b010 adds the result register; every other code adds zero. The sum wraps modulo 2^48.
- R4: With `z_sel` = 3'b010 and the result register present, every enabled clock edge adds the current product to the held result.
- R5: Setting `z_sel` to 3'b011 for a cycle during accumulation loads `c_in` plus the product, replacing the running sum. Accumulation then continues from that value.
- R6: `rst_p` high at a rising edge clears the result register to zero. It takes priority over `ce_p`.
- R7: A present register whose clock enable is low keeps its value, so changing an input behind it leaves the result unchanged.
- R8: Latency from an input to the result equals the number of registers present on its path. The A or D path counts the A/D register, the pre-add register, the product register and the result register. The C path counts the C register and the result register.
- R9: With every register parameter at 0 the result follows the inputs combinationally. Accumulate mode (3'b010) then adds zero.
- R10: `casc_out` always carries the same value as `p_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_p | input | 1 | Synchronous clear of the result register |
| a_in | input | 30 | Pre-adder operand; low 25 bits used, signed |
| d_in | input | 25 | Second pre-adder operand, signed |
| b_in | input | 18 | Multiplier operand, signed |
| c_in | input | 48 | Side operand for the post-adder |
| casc_in | input | 48 | Result of the neighbouring slice |
| pre_mode | input | 5 | Pre-adder mode code (5'b00100 enables the sum) |
| z_sel | input | 3 | Post-adder source select |
| ce_a | input | 1 | Clock enable, A register |
| ce_b | input | 1 | Clock enable, B register |
| ce_c | input | 1 | Clock enable, C register |
| ce_d | input | 1 | Clock enable, D register |
| ce_ad | input | 1 | Clock enable, pre-add sum register |
| ce_m | input | 1 | Clock enable, product register |
| ce_p | input | 1 | Clock enable, result register |
| p_out | output | 48 | Result |
| casc_out | output | 48 | Copy of the result for the next slice |

## Verification
The checker assumes the result register is present and treats `rst_p` as the only thing that may override the post-adder. Its source-select properties therefore hold only while `ce_p` is high and the clear is low. Each property compares the result with the post-adder's two inputs one cycle earlier. This means pipeline alignment in front of the post-adder is not assumed. The stimulus holds the operand inputs steady long enough to fill every stage before a value is compared. It changes only one input at a time when it measures latency, and it runs the large operand sweep on an instance with no registers, so the checks never depend on partly filled stages.

// File: rtl/premac_pkg.sv
package premac_pkg;
   // post-adder source select codes
   typedef enum logic [2:0] {
      ZS_ZERO  = 3'b000,
      ZS_ACCUM = 3'b010,
      ZS_SIDE  = 3'b011,
      ZS_CASC  = 3'b101
   } zsel_e;

   localparam logic [4:0] PREMODE_SUM = 5'b00100;
endpackage

// File: rtl/premac_opreg.sv
module premac_opreg #(
   parameter int W       = 8,
   parameter bit PRESENT = 1'b1,
   parameter bit HAS_CLR = 1'b0
) (
   input  logic         clk,
   input  logic         ce,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (PRESENT) begin : g_reg
      logic [W-1:0] q_r;
      if (HAS_CLR) begin : g_clr
         always_ff @(posedge clk) begin
            if (clr)     q_r <= '0;
            else if (ce) q_r <= d;
         end
      end else begin : g_noclr
         logic unused_clr;
         assign unused_clr = clr;
         always_ff @(posedge clk) begin
            if (ce) q_r <= d;
         end
      end
      assign q = q_r;
   end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ce ^ clr;
      assign q = d;
   end
endmodule

// File: rtl/premac_preadd.sv
module premac_preadd
   import premac_pkg::*;
#(
   parameter int PRE_W = 25
) (
   input  logic [PRE_W-1:0] a_lo,
   input  logic [PRE_W-1:0] d_val,
   input  logic [4:0]       mode,
   output logic [PRE_W-1:0] pre_out
);
   always_comb begin
      if (mode == PREMODE_SUM) pre_out = a_lo + d_val;
      else                     pre_out = a_lo;
   end
endmodule

// File: rtl/premac_mult.sv
module premac_mult #(
   parameter int PRE_W = 25,
   parameter int B_W   = 18,
   parameter int P_W   = 48
) (
   input  logic [PRE_W-1:0] pre_i,
   input  logic [B_W-1:0]   b_i,
   output logic [P_W-1:0]   prod_o
);
   localparam int PROD_W = PRE_W + B_W;
   logic signed [PROD_W-1:0] ea, eb, full;
   always_comb begin
      ea     = PROD_W'($signed(pre_i));
      eb     = PROD_W'($signed(b_i));
      full   = ea * eb;
      prod_o = P_W'(full);
   end
endmodule

// File: rtl/premac_postadd.sv
module premac_postadd
   import premac_pkg::*;
#(
   parameter int P_W   = 48,
   parameter int SHIFT = 17
) (
   input  logic [2:0]     zsel,
   input  logic [P_W-1:0] prod_i,
   input  logic [P_W-1:0] side_i,
   input  logic [P_W-1:0] fb_i,
   input  logic [P_W-1:0] casc_i,
   output logic [P_W-1:0] sum_o
);
   logic [P_W-1:0] zterm;
   always_comb begin
      unique case (zsel)
         ZS_SIDE:  zterm = side_i;
         ZS_ACCUM: zterm = fb_i;
         ZS_CASC:  zterm = P_W'($signed(casc_i) >>> SHIFT);
         default:  zterm = '0;
      endcase
      sum_o = prod_i + zterm;
   end
endmodule

// File: rtl/premac_slice.sv
module premac_slice #(
   parameter int A_W        = 30,
   parameter int B_W        = 18,
   parameter int D_W        = 25,
   parameter int P_W        = 48,
   parameter int CASC_SHIFT = 17,
   parameter bit AREG  = 1'b1,
   parameter bit BREG  = 1'b1,
   parameter bit CREG  = 1'b1,
   parameter bit DREG  = 1'b1,
   parameter bit ADREG = 1'b1,
   parameter bit MREG  = 1'b1,
   parameter bit PREG  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_p,
   input  logic [A_W-1:0] a_in,
   input  logic [D_W-1:0] d_in,
   input  logic [B_W-1:0] b_in,
   input  logic [P_W-1:0] c_in,
   input  logic [P_W-1:0] casc_in,
   input  logic [4:0]     pre_mode,
   input  logic [2:0]     z_sel,
   input  logic           ce_a,
   input  logic           ce_b,
   input  logic           ce_c,
   input  logic           ce_d,
   input  logic           ce_ad,
   input  logic           ce_m,
   input  logic           ce_p,
   output logic [P_W-1:0] p_out,
   output logic [P_W-1:0] casc_out
);
   localparam int PRE_W = D_W;

   if (PRE_W > A_W) begin : g_bad_width
      $error("premac_slice: D width exceeds A width");
   end
   if (PRE_W + B_W > P_W) begin : g_bad_prod
      $error("premac_slice: product wider than result");
   end
   if (CASC_SHIFT >= P_W || CASC_SHIFT < 1) begin : g_bad_shift
      $error("premac_slice: cascade shift out of range");
   end

   logic [PRE_W-1:0] a_stage, d_stage, pre_sum, ad_stage;
   logic [B_W-1:0]   b_stage;
   logic [P_W-1:0]   c_stage, prod, m_stage, sum, p_q, fb;

   if (A_W > PRE_W) begin : g_a_hi
      logic unused_a_hi;
      assign unused_a_hi = ^a_in[A_W-1:PRE_W];
   end

   premac_opreg #(.W(PRE_W), .PRESENT(AREG)) u_areg (
      .clk(clk), .ce(ce_a), .clr(1'b0), .d(a_in[PRE_W-1:0]), .q(a_stage));
   premac_opreg #(.W(PRE_W), .PRESENT(DREG)) u_dreg (
      .clk(clk), .ce(ce_d), .clr(1'b0), .d(d_in), .q(d_stage));
   premac_opreg #(.W(B_W), .PRESENT(BREG)) u_breg (
      .clk(clk), .ce(ce_b), .clr(1'b0), .d(b_in), .q(b_stage));
   premac_opreg #(.W(P_W), .PRESENT(CREG)) u_creg (
      .clk(clk), .ce(ce_c), .clr(1'b0), .d(c_in), .q(c_stage));

   premac_preadd #(.PRE_W(PRE_W)) u_preadd (
      .a_lo(a_stage), .d_val(d_stage), .mode(pre_mode), .pre_out(pre_sum));

   premac_opreg #(.W(PRE_W), .PRESENT(ADREG)) u_adreg (
      .clk(clk), .ce(ce_ad), .clr(1'b0), .d(pre_sum), .q(ad_stage));

   premac_mult #(.PRE_W(PRE_W), .B_W(B_W), .P_W(P_W)) u_mult (
      .pre_i(ad_stage), .b_i(b_stage), .prod_o(prod));

   premac_opreg #(.W(P_W), .PRESENT(MREG)) u_mreg (
      .clk(clk), .ce(ce_m), .clr(1'b0), .d(prod), .q(m_stage));

   // feedback exists only when the result is registered
   if (PREG) begin : g_fb
      assign fb = p_q;
   end else begin : g_nofb
      assign fb = '0;
   end

   premac_postadd #(.P_W(P_W), .SHIFT(CASC_SHIFT)) u_post (
      .zsel(z_sel), .prod_i(m_stage), .side_i(c_stage), .fb_i(fb),
      .casc_i(casc_in), .sum_o(sum));

   premac_opreg #(.W(P_W), .PRESENT(PREG), .HAS_CLR(1'b1)) u_preg (
      .clk(clk), .ce(ce_p), .clr(rst_p), .d(sum), .q(p_q));

   assign p_out    = p_q;
   assign casc_out = p_q;
endmodule

// File: rtl/premac_checker.sv
module premac_checker #(
   parameter int P_W   = 48,
   parameter int SHIFT = 17,
   parameter bit PREG  = 1'b1
) (
   input logic           clk,
   input logic           rst_p,
   input logic           ce_p,
   input logic [2:0]     z_sel,
   input logic [P_W-1:0] c_stage,
   input logic [P_W-1:0] m_stage,
   input logic [P_W-1:0] casc_in,
   input logic [P_W-1:0] p_out
);
   if (PREG) begin : g_chk
      logic [P_W-1:0] casc_sh;
      assign casc_sh = P_W'($signed(casc_in) >>> SHIFT);

      AST_CLEAR_ZERO: assert property (@(posedge clk)
         rst_p |=> p_out == '0); // R6
      AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst_p)
         !ce_p |=> $stable(p_out)); // R7
      AST_ACCUM_ADD: assert property (@(posedge clk) disable iff (rst_p)
         (ce_p && z_sel == 3'b010) |=> p_out == $past(p_out) + $past(m_stage)); // R4
      AST_SIDE_ADD: assert property (@(posedge clk) disable iff (rst_p)
         (ce_p && z_sel == 3'b011) |=> p_out == $past(c_stage) + $past(m_stage)); // R5
      AST_CASC_ADD: assert property (@(posedge clk) disable iff (rst_p)
         (ce_p && z_sel == 3'b101) |=> p_out == $past(casc_sh) + $past(m_stage)); // R3
   end else begin : g_nochk
      logic unused_all;
      assign unused_all = ^{clk, rst_p, ce_p, z_sel, c_stage, m_stage, casc_in, p_out};
   end
endmodule

bind premac_slice premac_checker #(.P_W(P_W), .SHIFT(CASC_SHIFT), .PREG(PREG)) u_chk (
   .clk(clk), .rst_p(rst_p), .ce_p(ce_p), .z_sel(z_sel), .c_stage(c_stage),
   .m_stage(m_stage), .casc_in(casc_in), .p_out(p_out));

// File: tb/premac_slice_bench.sv
module premac_slice_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_p;
   logic [29:0] a_in;
   logic [24:0] d_in;
   logic [17:0] b_in;
   logic [47:0] c_in, casc_in;
   logic [4:0]  pre_mode;
   logic [2:0]  z_sel;
   logic ce_a, ce_b, ce_c, ce_d, ce_ad, ce_m, ce_p;
   logic [47:0] p_out, casc_out, p_comb, casc_comb;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   premac_slice u_premac_slice (
      .clk(clk), .rst_p(rst_p), .a_in(a_in), .d_in(d_in), .b_in(b_in),
      .c_in(c_in), .casc_in(casc_in), .pre_mode(pre_mode), .z_sel(z_sel),
      .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d), .ce_ad(ce_ad),
      .ce_m(ce_m), .ce_p(ce_p), .p_out(p_out), .casc_out(casc_out));

   premac_slice #(.AREG(0), .BREG(0), .CREG(0), .DREG(0), .ADREG(0),
                  .MREG(0), .PREG(0)) u_premac_slice_comb (
      .clk(clk), .rst_p(rst_p), .a_in(a_in), .d_in(d_in), .b_in(b_in),
      .c_in(c_in), .casc_in(casc_in), .pre_mode(pre_mode), .z_sel(z_sel),
      .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d), .ce_ad(ce_ad),
      .ce_m(ce_m), .ce_p(ce_p), .p_out(p_comb), .casc_out(casc_comb));

   function automatic logic [47:0] model(logic [29:0] a, logic [24:0] d, logic [17:0] b,
                                         logic [4:0] mode, logic [2:0] zs, logic [47:0] c,
                                         logic [47:0] cas, logic [47:0] fb);
      logic signed [24:0] pre;
      logic signed [47:0] prod, z;
      if (mode == 5'b00100) pre = $signed(a[24:0]) + $signed(d);
      else                  pre = $signed(a[24:0]);
      prod = 48'(pre) * 48'($signed(b));
      case (zs)
         3'b011:  z = c;
         3'b010:  z = fb;
         3'b101:  z = $signed(cas) >>> 17;
         default: z = '0;
      endcase
      return prod + z;
   endfunction

   task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [47:0] k, e;
      rst_p = 1'b1; a_in = '0; d_in = '0; b_in = '0; c_in = '0; casc_in = '0;
      pre_mode = 5'b00000; z_sel = 3'b011;
      {ce_a, ce_b, ce_c, ce_d, ce_ad, ce_m, ce_p} = 7'h7f;
      tick(2);
      chk("R6 reset state", p_out, 48'h0);
      chk("R10 cascade at reset", casc_out, 48'h0);
      rst_p = 1'b0;

      // R9/R1/R2: combinational sweep on the register-free instance
      for (int ia = -4; ia < 4; ia++)
         for (int id = -4; id < 4; id++)
            for (int ib = -4; ib < 4; ib++)
               for (int im = 0; im < 2; im++) begin
                  a_in = {5'b10101, 25'(ia)};
                  d_in = 25'(id * 1000 + 7);
                  b_in = 18'(ib * 333);
                  pre_mode = (im != 0) ? 5'b00100 : 5'b00101;
                  c_in = 48'h0000_1234_5678 + 48'(ia * 64 + id);
                  z_sel = 3'b011;
                  #1;
                  chk("R9 R1 R2 comb sweep", p_comb,
                      model(a_in, d_in, b_in, pre_mode, z_sel, c_in, casc_in, 48'h0));
                  @(negedge clk);
               end

      // R1 wrap and R2 extremes
      a_in = 30'(-(1 << 24)); d_in = 25'(-(1 << 24)); b_in = 18'h1ffff; pre_mode = 5'b00100;
      z_sel = 3'b000; #1;
      chk("R1 pre-add wrap", p_comb, 48'h0);
      pre_mode = 5'b00000; b_in = 18'h20000; #1;
      chk("R2 max product", p_comb, 48'h0200_0000_0000);
      a_in = 30'h3ff_ffff; b_in = 18'h3ffff; #1;
      chk("R2 sign extension", p_comb, model(a_in, d_in, b_in, pre_mode, 3'b000, c_in, casc_in, 0));
      chk("R10 casc mirror comb", casc_comb, p_comb);

      // R3 source selects on the comb instance
      a_in = 30'd100; d_in = 25'd5; b_in = 18'(-3); pre_mode = 5'b00100;
      casc_in = 48'h8000_0000_0000;
      z_sel = 3'b101; #1;
      chk("R3 cascade arith shift", p_comb, model(a_in, d_in, b_in, pre_mode, 3'b101, c_in, casc_in, 0));
      z_sel = 3'b010; #1;
      chk("R9 accum without P adds zero", p_comb, 48'(-315));
      z_sel = 3'b111; #1;
      chk("R3 other code adds zero", p_comb, 48'(-315));
      c_in = 48'hffff_ffff_ffff; z_sel = 3'b011; b_in = 18'd1; #1;
      chk("R3 sum wraps", p_comb, 48'd104);
      @(negedge clk);

      // registered instance: settle then check
      a_in = 30'd1234; d_in = 25'(-34); b_in = 18'd10; pre_mode = 5'b00100;
      c_in = 48'd500; casc_in = 48'h0; z_sel = 3'b011;
      tick(6);
      chk("R3 side operand registered", p_out, 48'd12500);
      chk("R10 casc mirror", casc_out, 48'd12500);

      // R8: C path latency 2
      c_in = 48'd900;
      tick(1);
      chk("R8 C path not yet", p_out, 48'd12500);
      tick(1);
      chk("R8 C path latency", p_out, 48'd12900);

      // R8: A path latency 4
      a_in = 30'd2234;
      tick(3);
      chk("R8 A path not yet", p_out, 48'd12900);
      tick(1);
      chk("R8 A path latency", p_out, 48'd22900);

      // R3 cascade registered
      casc_in = 48'hffff_fffe_0000; z_sel = 3'b101;
      tick(1);
      chk("R3 cascade registered", p_out, 48'd21999);

      // R7 ce_p hold
      z_sel = 3'b011; tick(1);
      ce_p = 1'b0; c_in = 48'd77;
      tick(4);
      chk("R7 ce_p low holds", p_out, 48'd22900);
      ce_p = 1'b1; tick(1);
      chk("R7 ce_p release", p_out, 48'd22077);

      // R7 ce_a hold
      ce_a = 1'b0; a_in = 30'd34;
      tick(6);
      chk("R7 ce_a low holds", p_out, 48'd22077);
      ce_a = 1'b1; tick(6);
      chk("R7 ce_a release", p_out, 48'd77);

      // R6 priority over ce_p
      ce_p = 1'b0; rst_p = 1'b1; tick(1);
      chk("R6 clear beats ce_p", p_out, 48'h0);
      ce_p = 1'b1;

      // R4 accumulate, R5 replace
      a_in = 30'd7; d_in = 25'd0; b_in = 18'd3; pre_mode = 5'b00100; c_in = 48'd1000;
      tick(6);
      k = 48'd21;
      z_sel = 3'b010; rst_p = 1'b1; tick(1);
      rst_p = 1'b0; tick(5);
      chk("R4 accumulate five", p_out, 5 * k);
      z_sel = 3'b011; tick(1);
      chk("R5 C replaces sum", p_out, 48'd1000 + k);
      z_sel = 3'b010; tick(2);
      e = 48'd1000 + 3 * k;
      chk("R5 accumulate resumes", p_out, e);
      chk("R10 casc after accum", casc_out, e);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule